// File: doc/BRIEF.md
# Gate-Drive Fault Supervisor

This block sits between the six PWM command lines of a three-phase bridge and the gate-drive enables. In normal operation each enable follows its active-low command, gated by a per-drive enable mask. Two already-digitised, clock-synchronous condition flags are watched: an over-current trip and a low-side supply undervoltage flag. A qualified condition latches a shutdown that forces all six enables off on the same clock edge. An active-low fault output follows after a separate programmable delay, and a two-bit cause field shows which condition set the latch.

The over-current trip is ignored during a blanking window after any change of the enable outputs. This hides the current spike that follows a switching edge. The undervoltage flag is never blanked. The latch has no release pin. It clears only after all three low-side commands have been held inactive (high) for a programmable number of consecutive cycles, with neither condition present. A synchronous reset puts the block into the latched state. All times are parameters counted in clock cycles.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `gate_en` is all zeros, `fault_n` is 0 and `fault_cause` is 2'b00. Reset leaves the block latched.
- R2: When not latched, `gate_en` is registered one cycle after its inputs. `gate_en[i]` equals `~hs_cmd_n[i] & drv_mask[i]` for phases i = 0..2. `gate_en[3+i]` equals `~ls_cmd_n[i] & drv_mask[3+i]`.
- R3: An `oc_trip` sampled high outside the blanking window clears all six bits of `gate_en` at that same edge and sets `fault_cause[0]`.
- R4: `oc_trip` is ignored at each of the BLANK_CYC edges that follow any edge where `gate_en` changed.
- R5: `fault_n` goes low exactly FLT_DLY cycles after the edge that forced `gate_en` off. It stays high before then.
- R6: `uv_flag` high latches the shutdown at the edge where it is sampled, even inside the blanking window, and sets `fault_cause[1]`.
- R7: The latch clears at the edge that completes CLR_CYC consecutive samples of `ls_cmd_n == 3'b111`, provided neither flag is high there. `fault_n` then returns high, `fault_cause` becomes 2'b00, and `gate_en` follows the commands again.
- R8: Any low-side command sampled low while latched restarts the clear count from zero.
- R9: If a flag is still high when the clear count completes, the block stays latched. It clears at the first later edge without a flag, as long as the low-side commands stay high.
- R10: While latched, `gate_en` stays all zeros whatever the high-side commands and the mask do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, enters the latched state |
| hs_cmd_n | input | NPH | High-side commands, active low, one per phase |
| ls_cmd_n | input | NPH | Low-side commands, active low, one per phase |
| drv_mask | input | 2*NPH | Per-drive enable mask, high-side bits low |
| oc_trip | input | 1 | Synchronous over-current trip flag, active high |
| uv_flag | input | 1 | Synchronous low-side undervoltage flag, active high |
| gate_en | output | 2*NPH | Registered gate-drive enables, high-side bits low |
| fault_n | output | 1 | Active-low fault indication (drive an open-drain pad) |
| fault_cause | output | 2 | Latch cause: bit 0 over-current, bit 1 undervoltage |

## Verification
The bench builds the block with BLANK_CYC = 3, FLT_DLY = 2 and CLR_CYC = 8. With these values the bench can step through every edge of the blanking window and confirm the first edge where a trip is honoured. It can also catch the fault indication cycle by cycle. Because the clear count is short, the bench can restart it part way through, and it can hold the undervoltage flag past the end of the count and then watch the release.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // cause bits reported on fault_cause
  typedef struct packed {
    logic uv;  // low-side supply undervoltage
    logic oc;  // over-current trip
  } cause_t;
endpackage

// File: rtl/fsup_blank_timer.sv
// Down counter that masks the trip input after a switching edge.
module fsup_blank_timer #(
  parameter int LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] START = W'(LEN);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= START;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fsup_hold_timer.sv
// Saturating counter of consecutive cycles with run high.
// full_now is high at the edge that completes LEN such cycles and
// at every later edge while run stays high.
module fsup_hold_timer #(
  parameter int LEN = 900
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic full_now
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] TOP  = W'(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + 1'b1;
  end

  assign full_now = run && (cnt >= LAST);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NPH       = 3,
  parameter int BLANK_CYC = 40,
  parameter int FLT_DLY   = 59,
  parameter int CLR_CYC   = 900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPH-1:0]    hs_cmd_n,
  input  logic [NPH-1:0]    ls_cmd_n,
  input  logic [2*NPH-1:0]  drv_mask,
  input  logic              oc_trip,
  input  logic              uv_flag,
  output logic [2*NPH-1:0]  gate_en,
  output logic              fault_n,
  output logic [1:0]        fault_cause
);
  localparam int NDRV = 2 * NPH;
  localparam int DW   = $clog2(FLT_DLY + 1);
  localparam logic [DW-1:0] DLY_END = DW'(FLT_DLY);

  logic            latched;
  cause_t          cause_q, cause_nxt;
  logic [DW-1:0]   dly_cnt, dly_nxt;
  logic [NDRV-1:0] cmd_on, gate_nxt;
  logic            blank_busy, clr_full;
  logic            oc_hit, set_now, clr_now, latch_nxt, flag_nxt;

  // trip qualification and latch control
  assign oc_hit    = oc_trip && !blank_busy;
  assign set_now   = oc_hit || uv_flag;
  assign clr_now   = latched && clr_full && !oc_trip && !uv_flag;
  assign latch_nxt = set_now || (latched && !clr_now);

  always_comb begin
    cause_nxt = cause_q;
    if (set_now) begin
      if (!latched) cause_nxt = '0;
      cause_nxt.oc = cause_nxt.oc | oc_hit;
      cause_nxt.uv = cause_nxt.uv | uv_flag;
    end else if (clr_now) begin
      cause_nxt = '0;
    end
  end

  // fault indication delay, counted from the shutdown edge
  always_comb begin
    dly_nxt = dly_cnt;
    if (set_now && !latched)               dly_nxt = '0;
    else if (latched && dly_cnt != DLY_END) dly_nxt = dly_cnt + 1'b1;
  end
  assign flag_nxt = latch_nxt && (dly_nxt == DLY_END);

  // drive path
  assign cmd_on   = {~ls_cmd_n, ~hs_cmd_n} & drv_mask;
  assign gate_nxt = latch_nxt ? '0 : cmd_on;

  fsup_blank_timer #(.LEN(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst  (rst),
    .load (gate_nxt != gate_en),
    .busy (blank_busy)
  );

  fsup_hold_timer #(.LEN(CLR_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .run      (latched && (&ls_cmd_n)),
    .full_now (clr_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= 1'b1;
      cause_q <= '0;
      dly_cnt <= DLY_END;
      gate_en <= '0;
      fault_n <= 1'b0;
    end else begin
      latched <= latch_nxt;
      cause_q <= cause_nxt;
      dly_cnt <= dly_nxt;
      gate_en <= gate_nxt;
      fault_n <= !flag_nxt;
    end
  end

  assign fault_cause = cause_q;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int NDRV = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [NDRV-1:0] gate_en,
  input logic            fault_n,
  input logic [1:0]      fault_cause,
  input logic            oc_trip,
  input logic            uv_flag,
  input logic            blank_busy
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && !fault_n && fault_cause == 2'b00));

  // R3
  a_r3_trip_shuts: assert property (@(posedge clk) disable iff (rst)
    (oc_trip && !blank_busy) |=> (gate_en == '0 && fault_cause[0]));

  // R6
  a_r6_uv_shuts: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> (gate_en == '0 && fault_cause[1]));

  // R5
  a_r5_flag_after_off: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> (gate_en == '0 && $past(gate_en) == '0));

  // R7
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> (fault_cause == 2'b00));

  // R10
  a_r10_fault_off: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_en == '0));
endmodule

bind fault_supervisor fsup_checker #(.NDRV(2 * NPH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gate_en     (gate_en),
  .fault_n     (fault_n),
  .fault_cause (fault_cause),
  .oc_trip     (oc_trip),
  .uv_flag     (uv_flag),
  .blank_busy  (blank_busy)
);

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int BLK = 3;
  localparam int FD  = 2;
  localparam int CLR = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hs_n = 3'b111, ls_n = 3'b111;
  logic [5:0] mask = 6'h3F;
  logic       trip = 1'b0, uv = 1'b0;
  logic [5:0] gate_en;
  logic       fault_n;
  logic [1:0] cause;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_supervisor #(.NPH(3), .BLANK_CYC(BLK), .FLT_DLY(FD), .CLR_CYC(CLR)) u0 (
    .clk(clk), .rst(rst), .hs_cmd_n(hs_n), .ls_cmd_n(ls_n), .drv_mask(mask),
    .oc_trip(trip), .uv_flag(uv), .gate_en(gate_en), .fault_n(fault_n),
    .fault_cause(cause));

  // {hs_n, ls_n, mask, expected gate_en}
  localparam logic [17:0] VEC [6] = '{
    {3'b011, 3'b111, 6'h3F, 6'b000100},
    {3'b111, 3'b110, 6'h3F, 6'b001000},
    {3'b010, 3'b101, 6'h3F, 6'b010101},
    {3'b000, 3'b000, 6'h2A, 6'b101010},
    {3'b000, 3'b111, 6'h03, 6'b000011},
    {3'b111, 3'b111, 6'h3F, 6'b000000}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 gate", {2'b0, gate_en}, 8'h00);
    check("R1 fault_n", {7'b0, fault_n}, 8'h00);
    check("R1 cause", {6'b0, cause}, 8'h00);
    rst = 1'b0;
    repeat (CLR - 1) tick();
    check("R7 still latched before count ends", {7'b0, fault_n}, 8'h00);
    tick();
    check("R7 released after reset", {7'b0, fault_n}, 8'h01);

    // R2 table walk
    for (int i = 0; i < 6; i++) begin
      {hs_n, ls_n, mask} = VEC[i][17:6];
      tick();
      check("R2 drive follow", {2'b0, gate_en}, {2'b0, VEC[i][5:0]});
    end

    // switching edge G, then trip inside blanking window
    hs_n = 3'b110;
    tick();
    check("R2 edge", {2'b0, gate_en}, 8'h01);
    trip = 1'b1;
    for (int k = 0; k < BLK; k++) begin
      tick();
      check("R4 trip blanked", {2'b0, gate_en}, 8'h01);
    end
    tick();  // edge E
    check("R3 all off", {2'b0, gate_en}, 8'h00);
    check("R3 cause oc", {6'b0, cause}, 8'h01);
    check("R5 no early flag", {7'b0, fault_n}, 8'h01);
    trip = 1'b0; ls_n = 3'b110; hs_n = 3'b000;
    tick();
    check("R5 flag not yet", {7'b0, fault_n}, 8'h01);
    check("R10 hs ignored", {2'b0, gate_en}, 8'h00);
    tick();
    check("R5 flag at delay", {7'b0, fault_n}, 8'h00);

    // clear with restart
    ls_n = 3'b111;
    repeat (5) tick();
    ls_n = 3'b011;
    tick();
    ls_n = 3'b111;
    repeat (CLR - 1) tick();
    check("R8 restart holds latch", {7'b0, fault_n}, 8'h00);
    check("R10 still off", {2'b0, gate_en}, 8'h00);
    tick();
    check("R7 fault released", {7'b0, fault_n}, 8'h01);
    check("R7 cause cleared", {6'b0, cause}, 8'h00);
    check("R7 drive resumes", {2'b0, gate_en}, 8'h07);

    // undervoltage inside blanking window, held past clear count
    uv = 1'b1;
    tick();
    check("R6 uv off", {2'b0, gate_en}, 8'h00);
    check("R6 cause uv", {6'b0, cause}, 8'h02);
    repeat (CLR) tick();
    check("R9 held by uv", {7'b0, fault_n}, 8'h00);
    check("R9 cause kept", {6'b0, cause}, 8'h02);
    uv = 1'b0;
    tick();
    check("R9 release after uv", {7'b0, fault_n}, 8'h01);
    check("R9 drive resumes", {2'b0, gate_en}, 8'h07);

    // reset from running state
    rst = 1'b1;
    tick();
    check("R1 reset gate", {2'b0, gate_en}, 8'h00);
    check("R1 reset fault_n", {7'b0, fault_n}, 8'h00);
    check("R1 reset cause", {6'b0, cause}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule